// File: doc/BRIEF.md
# Programmable Baud Tick Generator with Aliased Divisor Latch

This block derives the 16x oversampling tick used by a serial transmitter and receiver from a fixed reference clock of about 1.84 MHz. A 16-bit divisor sets the tick spacing: the divisor equals the reference frequency divided by sixteen times the wanted baud rate. Some standard values are 1 for 115200 baud, 12 for 9600, 96 for 1200 and 2304 for 50. Sixteen ticks make one bit period.

Software reaches the divisor through a byte-wide register bus. The two divisor bytes share bus offsets 0 and 1 with a data holding register and an interrupt-enable register. Bit 7 of a line control register at offset 3 selects which pair is reached. A write to either divisor byte restarts the tick counter, so a new rate takes effect from that write. A divisor of zero silences the tick output.

The register bus carries only register accesses and no data stream. It is therefore a plain strobe bus that takes every write in the cycle it is presented, with no back-pressure. Reads are combinational from the offset.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset the divisor is 12 and line-control bit 7 is 0. The tick is low, and the first tick appears on the 12th rising clock edge after reset is released.
- R2: While line-control bit 7 is 1, a write to offset 0 loads the divisor low byte and a write to offset 1 loads the high byte. Both offsets read back the stored byte.
- R3: While line-control bit 7 is 0, offset 0 reaches an 8-bit data holding register and offset 1 reaches the interrupt-enable register. The interrupt-enable register keeps bits 3:0 and reads 0 in bits 7:4. The divisor is left unchanged.
- R4: With a divisor D of 2 or more, `tick_o` is high for one clock in every D clocks.
- R5: A write to either divisor byte restarts the counter. The next tick appears on the D-th rising edge after the write edge, where D is the newly written divisor.
- R6: With a divisor of 0, `tick_o` stays low.
- R7: Offset 3 stores bit 7 of each write to it and reads back {bit7, 7'b0}. Offset 2 and offsets 4 to 7 read as 0 and ignore writes.
- R8: With a divisor of 1, `tick_o` is high on every clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| addr | input | 3 | Register offset |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Read data for `addr`, combinational |
| tick_o | output | 1 | 16x oversampling tick |

## Verification
A wrong divisor byte is visible at once on a read of offset 0 or 1 with bit 7 set. It also moves the first tick after the next restart by the size of the error. A miscounted counter shows up as a first tick that arrives early or late, or as two ticks whose spacing is not D. This appears within one divisor period of any restart. A wrong access-bit state shows up on the next read of offset 3. It also shows as a data or enable write that corrupts the divisor, which is seen on a divisor read made afterwards.

// File: rtl/baud_pkg.sv
package baud_pkg;
  typedef enum logic [2:0] {
    OFS_LANE0 = 3'd0,
    OFS_LANE1 = 3'd1,
    OFS_SPARE = 3'd2,
    OFS_LINE  = 3'd3
  } reg_ofs_e;

  localparam int BUS_W    = 8;
  localparam int LATCH_BIT = 7;
  localparam int IEN_W    = 4;
endpackage

// File: rtl/baud_div_latch.sv
module baud_div_latch
  import baud_pkg::*;
#(
  parameter int DIV_W   = 16,
  parameter int RST_DIV = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       addr,
  input  logic [BUS_W-1:0] wdata,
  input  logic             latch_sel,
  output logic [DIV_W-1:0] div_q,
  output logic [DIV_W-1:0] div_next,
  output logic             restart
);
  localparam int LANES = DIV_W / BUS_W;
  localparam logic [DIV_W-1:0] RST_VAL = DIV_W'(RST_DIV);

  logic [LANES-1:0] lane_we;

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_lane
      assign lane_we[g] = wr_en && latch_sel && (addr == 3'(g));
    end
  endgenerate

  always_comb begin
    div_next = div_q;
    for (int b = 0; b < LANES; b++) begin
      if (lane_we[b]) div_next[b*BUS_W +: BUS_W] = wdata;
    end
  end

  assign restart = |lane_we;

  always_ff @(posedge clk) begin
    if (!rst_n) div_q <= RST_VAL;
    else        div_q <= div_next;
  end
endmodule

// File: rtl/baud_side_regs.sv
module baud_side_regs
  import baud_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       addr,
  input  logic [BUS_W-1:0] wdata,
  output logic             latch_sel,
  output logic [BUS_W-1:0] hold_q,
  output logic [IEN_W-1:0] ien_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latch_sel <= 1'b0;
      hold_q    <= '0;
      ien_q     <= '0;
    end else if (wr_en) begin
      case (reg_ofs_e'(addr))
        OFS_LINE:  latch_sel <= wdata[LATCH_BIT];
        OFS_LANE0: if (!latch_sel) hold_q <= wdata;
        OFS_LANE1: if (!latch_sel) ien_q  <= wdata[IEN_W-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/baud_divider.sv
module baud_divider #(
  parameter int DIV_W   = 16,
  parameter int RST_DIV = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [DIV_W-1:0] div_next,
  input  logic [DIV_W-1:0] div_q,
  output logic             tick_o
);
  localparam logic [DIV_W-1:0] RST_CNT = (RST_DIV > 0) ? DIV_W'(RST_DIV - 1) : '0;

  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= RST_CNT;
      tick_o <= 1'b0;
    end else if (restart) begin
      cnt_q  <= (div_next == '0) ? '0 : div_next - 1'b1;
      tick_o <= 1'b0;
    end else if (div_q == '0) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else if (cnt_q == '0) begin
      cnt_q  <= div_q - 1'b1;
      tick_o <= 1'b1;
    end else begin
      cnt_q  <= cnt_q - 1'b1;
      tick_o <= 1'b0;
    end
  end
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
  import baud_pkg::*;
#(
  parameter int DIV_W   = 16,
  parameter int RST_DIV = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [2:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       tick_o
);
  logic             latch_sel;
  logic [BUS_W-1:0] hold_q;
  logic [IEN_W-1:0] ien_q;
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] div_next;
  logic             restart;

  baud_side_regs u_side (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .latch_sel(latch_sel), .hold_q(hold_q), .ien_q(ien_q)
  );

  baud_div_latch #(.DIV_W(DIV_W), .RST_DIV(RST_DIV)) u_latch (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .latch_sel(latch_sel), .div_q(div_q), .div_next(div_next), .restart(restart)
  );

  baud_divider #(.DIV_W(DIV_W), .RST_DIV(RST_DIV)) u_div (
    .clk(clk), .rst_n(rst_n), .restart(restart), .div_next(div_next),
    .div_q(div_q), .tick_o(tick_o)
  );

  always_comb begin
    case (reg_ofs_e'(addr))
      OFS_LANE0: rdata = latch_sel ? div_q[BUS_W-1:0] : hold_q;
      OFS_LANE1: rdata = latch_sel ? div_q[2*BUS_W-1:BUS_W]
                                   : {{(BUS_W-IEN_W){1'b0}}, ien_q};
      OFS_LINE:  rdata = {latch_sel, 7'b0};
      default:   rdata = '0;
    endcase
  end
endmodule

// File: rtl/baud_tick_gen_chk.sv
module baud_tick_gen_chk #(
  parameter int DIV_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [2:0]       addr,
  input logic [7:0]       wdata,
  input logic             tick_o,
  input logic             latch_sel,
  input logic [DIV_W-1:0] div_q
);
  AST_ZERO_DIV_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (div_q == '0) |=> !tick_o); // R6

  AST_RESTART_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && latch_sel && addr <= 3'd1) |=> !tick_o); // R5

  AST_DIV_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !latch_sel && addr <= 3'd1) |=> $stable(div_q)); // R3

  AST_LOW_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && latch_sel && addr == 3'd0) |=> (div_q[7:0] == $past(wdata))); // R2

  AST_LINE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd3) |=> (latch_sel == $past(wdata[7]))); // R7

  AST_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && $past(tick_o)) |-> (div_q == DIV_W'(1))); // R4
endmodule

bind baud_tick_gen baud_tick_gen_chk #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .tick_o(tick_o), .latch_sel(latch_sel), .div_q(div_q)
);

// File: tb/baud_tick_gen_test.sv
module baud_tick_gen_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       tick_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  baud_tick_gen uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .tick_o(tick_o)
  );

  always #4 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // called at a negedge, returns at the next negedge
  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    addr = a;
    #1;
    v = int'(rdata);
  endtask

  // set divisor with access bit on; the high-byte write is the restart edge
  task automatic set_div(input int d);
    wr(3'd3, 8'h80);
    wr(3'd0, 8'(d));
    wr(3'd1, 8'(d >> 8));
  endtask

  // count from the restart edge: first tick and number of ticks in 3*D
  task automatic measure(input int d, input string req);
    int first = -1;
    int cnt = 0;
    for (int n = 1; n <= 3 * d; n++) begin
      @(negedge clk);
      if (tick_o) begin
        cnt++;
        if (first < 0) first = n;
      end
    end
    chk({req, " first tick"}, first, d);
    chk({req, " tick count"}, cnt, 3);
  endtask

  task automatic t_reset;
    int first = -1;
    int v;
    chk("R1 tick low in reset", int'(tick_o), 0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int n = 1; n <= 14; n++) begin
      @(negedge clk);
      if (tick_o && first < 0) first = n;
    end
    chk("R1 first tick after reset", first, 12);
    rd(3'd3, v);
    chk("R1 line bit clear", v, 0);
    wr(3'd3, 8'h80);
    rd(3'd0, v); chk("R1 reset divisor low", v, 12);
    rd(3'd1, v); chk("R1 reset divisor high", v, 0);
  endtask

  task automatic t_readback;
    int v;
    wr(3'd3, 8'h80);
    wr(3'd0, 8'h34);
    wr(3'd1, 8'h12);
    rd(3'd0, v); chk("R2 low byte readback", v, 8'h34);
    rd(3'd1, v); chk("R2 high byte readback", v, 8'h12);
  endtask

  task automatic t_alias;
    int v;
    wr(3'd3, 8'h00);
    wr(3'd0, 8'hA5);
    wr(3'd1, 8'hFF);
    rd(3'd0, v); chk("R3 data register", v, 8'hA5);
    rd(3'd1, v); chk("R3 enable register", v, 8'h0F);
    wr(3'd3, 8'h80);
    rd(3'd0, v); chk("R3 divisor low kept", v, 8'h34);
    rd(3'd1, v); chk("R3 divisor high kept", v, 8'h12);
  endtask

  task automatic t_line;
    int v;
    wr(3'd3, 8'hFF);
    rd(3'd3, v); chk("R7 line readback", v, 8'h80);
    wr(3'd2, 8'h77);
    rd(3'd2, v); chk("R7 offset 2 reads zero", v, 0);
    wr(3'd5, 8'h55);
    rd(3'd5, v); chk("R7 offset 5 reads zero", v, 0);
    rd(3'd0, v); chk("R7 divisor low unaffected", v, 8'h34);
  endtask

  task automatic t_period(input int d);
    set_div(d);
    measure(d, (d == 1) ? "R8" : "R4");
  endtask

  task automatic t_restart;
    set_div(12);
    repeat (5) @(negedge clk);
    wr(3'd0, 8'd12);
    measure(12, "R5");
    set_div(96);
    repeat (30) @(negedge clk);
    wr(3'd0, 8'd24);
    measure(24, "R5 new value");
  endtask

  task automatic t_zero;
    int cnt = 0;
    set_div(0);
    for (int n = 0; n < 200; n++) begin
      @(negedge clk);
      if (tick_o) cnt++;
    end
    chk("R6 no tick with zero", cnt, 0);
  endtask

  initial begin
    t_reset();
    t_readback();
    t_alias();
    t_line();
    t_period(12);
    t_period(96);
    t_period(2304);
    t_period(1);
    t_period(2);
    t_restart();
    t_zero();
    t_period(12);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule